// File: doc/BRIEF.md
# Management-Bus PHY Address Scanner

This block is a small sequencer that sits above a management-interface (MDIO) master and locates the first Ethernet PHY that answers on the bus. After a start pulse it waits for a settling interval, measured in a slow tick input, and then probes every management address from the lowest to the highest. At each address it reads the lower identifier register. A value of all ones means that nobody drives the bus there. When a device does answer, the block also reads the upper identifier register at the same address, and then it reports the address and the combined 32-bit identifier.

A PHY that is still coming out of reset may not answer on the first sweep. For this reason the block repeats the full sweep, with a fresh settling wait before each one, until it has used up a fixed number of passes. It then reports either the device it found or a "none" result. The scan only issues read requests. Each request is held on a level request line together with an address and a register number until the master returns a one-cycle acknowledge with the read data. The master then turns the request into MDIO frames.

Top module: `phy_scan`

## Requirements
- R1: After reset, busy, done, found and mdio_req are 0, phy_addr is all ones, phy_id is 0 and pass_num is 0.
- R2: A start pulse while idle raises busy on the next clock edge, and busy stays high until completion. A start pulse while busy is ignored: the scan in progress goes on without restarting, and its pass count does not reset.
- R3: Before each pass, including the first, the block issues no request until WAIT_TICKS tick pulses have been seen since that pass's wait began.
- R4: Within a pass, lower-identifier reads (register number 3) go to addresses 0, 1, 2, ... in ascending order. Address, register and request are held stable until mdio_ack.
- R5: A register-3 read that returns 16'hFFFF marks the address as empty, and the scan moves on to the next address. After the empty result at the last address, the pass ends.
- R6: A register-3 read that returns any other value is followed by a register-2 read at the same address. phy_id is then {register-2 data, register-3 data}, so register 2 occupies bits 31:16. The scan stops at that address, even when the register-2 data is 16'hFFFF.
- R7: When the scan completes, done pulses for exactly one cycle as busy falls. On success, found is 1, phy_addr holds the responding address and pass_num holds the 1-based pass in which it answered.
- R8: When MAX_PASSES passes all find nothing, done pulses with found 0, phy_addr all ones, phy_id 0 and pass_num equal to MAX_PASSES.
- R9: phy_id_masked equals phy_id with bits 3:0 (the revision field) forced to zero.
- R10: The results (found, phy_addr, phy_id, pass_num) hold their values while idle, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a scan (taken only when idle) |
| tick | input | 1 | Settling-time tick, one pulse per time unit |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | A PHY answered |
| phy_addr | output | ADDR_W | Responding address, all ones for none |
| phy_id | output | 32 | {register 2, register 3} identifier |
| phy_id_masked | output | 32 | Identifier with revision nibble cleared |
| pass_num | output | PASS_W | Current or final pass number (1-based) |
| mdio_req | output | 1 | Read request to the management master |
| mdio_addr | output | ADDR_W | Address of the read |
| mdio_reg | output | 5 | Register number of the read |
| mdio_ack | input | 1 | Read complete, data valid |
| mdio_rdata | input | 16 | Read data |

## Verification
The bench builds the scanner with WAIT_TICKS set to 3 and MAX_PASSES set to 4, keeping the full 5-bit address space. A short wait and a small pass budget make a complete failed search of four full 32-address sweeps cheap to run. They also make it cheap to have a PHY that first answers on the last permitted pass, and one that would answer only after the budget is exhausted. With only three ticks per wait, the bench can also step the settling wait one tick at a time and observe the exact tick that releases the first request.

// File: rtl/phy_scan.sv
module phy_scan #(
  parameter int ADDR_W     = 5,
  parameter int MAX_PASSES = 11,
  parameter int WAIT_TICKS = 10,
  parameter int HI_REG     = 2,
  parameter int LO_REG     = 3,
  localparam int PASS_W    = $clog2(MAX_PASSES + 1),
  localparam int WCNT_W    = $clog2(WAIT_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [31:0]       phy_id,
  output logic [31:0]       phy_id_masked,
  output logic [PASS_W-1:0] pass_num,
  output logic              mdio_req,
  output logic [ADDR_W-1:0] mdio_addr,
  output logic [4:0]        mdio_reg,
  input  logic              mdio_ack,
  input  logic [15:0]       mdio_rdata
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [15:0]       ABSENT    = 16'hFFFF;
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(MAX_PASSES);
  localparam logic [WCNT_W-1:0] LAST_TICK = WCNT_W'(WAIT_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LO, S_HI} state_t;
  state_t st;
  logic [WCNT_W-1:0] wcnt;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       lo_word;

  assign busy          = (st != S_IDLE);
  assign mdio_req      = (st == S_LO) || (st == S_HI);
  assign mdio_addr     = addr;
  assign mdio_reg      = (st == S_HI) ? 5'(HI_REG) : 5'(LO_REG);
  assign phy_id_masked = {phy_id[31:4], 4'h0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wcnt     <= '0;
      addr     <= '0;
      lo_word  <= '0;
      done     <= 1'b0;
      found    <= 1'b0;
      phy_addr <= '1;
      phy_id   <= '0;
      pass_num <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_WAIT;
          wcnt     <= '0;
          found    <= 1'b0;
          phy_addr <= '1;
          phy_id   <= '0;
          pass_num <= PASS_W'(1);
        end
        S_WAIT: if (tick) begin
          if (wcnt == LAST_TICK) begin
            st   <= S_LO;
            addr <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_LO: if (mdio_ack) begin
          if (mdio_rdata != ABSENT) begin
            lo_word <= mdio_rdata;
            st      <= S_HI;
          end else if (addr != LAST_ADDR) begin
            addr <= addr + 1'b1;
          end else if (pass_num == LAST_PASS) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st       <= S_WAIT;
            wcnt     <= '0;
            pass_num <= pass_num + 1'b1;
          end
        end
        S_HI: if (mdio_ack) begin
          st       <= S_IDLE;
          done     <= 1'b1;
          found    <= 1'b1;
          phy_addr <= addr;
          phy_id   <= {mdio_rdata, lo_word};
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_req_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> busy);
  a_r4_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_ack) |=> (mdio_req && $stable(mdio_addr) && $stable(mdio_reg)));
  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r8_none_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (phy_addr == LAST_ADDR && pass_num == LAST_PASS && phy_id == 32'h0));
  a_r8_pass_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pass_num <= LAST_PASS);
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(found) && $stable(phy_addr) && $stable(phy_id) && $stable(pass_num)));
endmodule

// File: tb/phy_scan_tb.sv
module phy_scan_tb;
  localparam int AW = 5;
  localparam int MP = 4;
  localparam int WT = 3;
  localparam int PW = $clog2(MP + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic tick_auto = 0, tick_gen = 0, tick_man = 0;
  logic mdio_ack = 0;
  logic [15:0] mdio_rdata = '0;
  logic busy, done, found, mdio_req;
  logic [AW-1:0] phy_addr, mdio_addr;
  logic [31:0] phy_id, phy_id_masked;
  logic [PW-1:0] pass_num;
  logic [4:0] mdio_reg;
  wire tick = tick_auto ? tick_gen : tick_man;

  int checks = 0, errors = 0;
  int m_addr = 0, m_appear = 1, m_seen = 0, exp_addr = 0, last_addr = 0;
  logic [31:0] m_id = '0;

  phy_scan #(.ADDR_W(AW), .MAX_PASSES(MP), .WAIT_TICKS(WT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .busy(busy), .done(done),
    .found(found), .phy_addr(phy_addr), .phy_id(phy_id), .phy_id_masked(phy_id_masked),
    .pass_num(pass_num), .mdio_req(mdio_req), .mdio_addr(mdio_addr), .mdio_reg(mdio_reg),
    .mdio_ack(mdio_ack), .mdio_rdata(mdio_rdata));

  always #5 clk = ~clk;
  always @(negedge clk) tick_gen <= ~tick_gen;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Responder: one cycle latency, then a one-cycle ack
  int lat = 0;
  always @(negedge clk) begin
    if (mdio_ack) mdio_ack = 0;
    else if (mdio_req) begin
      if (lat < 1) lat++;
      else begin
        lat = 0;
        mdio_ack = 1;
        if (mdio_reg == 5'd3) begin
          chk("R4 ascending probe", 32'(mdio_addr), 32'(exp_addr));
          last_addr = int'(mdio_addr);
          exp_addr = (int'(mdio_addr) + 1) % 32;
          if (int'(mdio_addr) == m_addr) begin
            m_seen++;
            mdio_rdata = (m_seen >= m_appear) ? m_id[15:0] : 16'hFFFF;
          end else mdio_rdata = 16'hFFFF;
        end else if (mdio_reg == 5'd2) begin
          chk("R6 same address", 32'(mdio_addr), 32'(last_addr));
          mdio_rdata = m_id[31:16];
        end else begin
          chk("R4 register number", 32'(mdio_reg), 32'd3);
          mdio_rdata = 16'hFFFF;
        end
      end
    end
  end

  task automatic setup(input int a, input int ap, input logic [31:0] id);
    m_addr = a; m_appear = ap; m_id = id; m_seen = 0; exp_addr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
    if (!ok) begin errors++; checks++; $display("FAIL R7: no done pulse, actual 0 expected 1"); end
  endtask

  task automatic check_result(input int a, input int ap, input logic [31:0] id);
    bit f = (ap <= MP);
    chk("R7 busy low at done", 32'(busy), 32'd0);
    chk(f ? "R7 found" : "R8 not found", 32'(found), 32'(f));
    chk(f ? "R7 address" : "R8 address none", 32'(phy_addr), f ? 32'(a) : 32'h1F);
    chk(f ? "R6 identifier" : "R8 identifier zero", phy_id, f ? id : 32'h0);
    chk(f ? "R7 pass number" : "R8 pass number", 32'(pass_num), f ? 32'(ap) : 32'(MP));
    chk("R9 masked id", phy_id_masked, (f ? id : 32'h0) & 32'hFFFF_FFF0);
  endtask

  // {address, first answering pass, identifier}
  localparam logic [39:0] VEC [6] = '{
    {5'd0,  3'd1, 32'h0013_78E3},
    {5'd31, 3'd1, 32'h0022_1455},
    {5'd7,  3'd3, 32'h0181_B88A},
    {5'd12, 3'd4, 32'h02A8_015F},
    {5'd9,  3'd7, 32'h1234_5678},
    {5'd4,  3'd2, 32'hFFFF_0001}
  };

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0); chk("R1 done", 32'(done), 0);
    chk("R1 found", 32'(found), 0); chk("R1 req", 32'(mdio_req), 0);
    chk("R1 addr", 32'(phy_addr), 32'h1F); chk("R1 id", phy_id, 0);
    chk("R1 pass", 32'(pass_num), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 settle wait stepped tick by tick
    setup(2, 1, 32'h0000_0042);
    pulse_start();
    chk("R2 busy after start", 32'(busy), 1);
    for (int i = 0; i < WT - 1; i++) begin
      @(negedge clk) tick_man = 1;
      @(negedge clk) tick_man = 0;
      repeat (3) @(negedge clk);
      chk("R3 no request before last tick", 32'(mdio_req), 0);
    end
    @(negedge clk) tick_man = 1;
    @(negedge clk) tick_man = 0;
    chk("R3 request after last tick", 32'(mdio_req), 1);
    tick_auto = 1;
    wait_done(ok);
    if (ok) begin
      check_result(2, 1, 32'h0000_0042);
      @(negedge clk);
      chk("R7 done one cycle", 32'(done), 0);
      repeat (20) @(negedge clk);
      chk("R10 address held", 32'(phy_addr), 2);
      chk("R10 id held", phy_id, 32'h0000_0042);
      chk("R10 found held", 32'(found), 1);
    end

    // Vector walk: R4, R5, R6, R7, R8, R9
    foreach (VEC[k]) begin
      setup(int'(VEC[k][39:35]), int'(VEC[k][34:32]), VEC[k][31:0]);
      pulse_start();
      wait_done(ok);
      if (ok) check_result(int'(VEC[k][39:35]), int'(VEC[k][34:32]), VEC[k][31:0]);
      @(negedge clk);
    end

    // R2 start while busy ignored
    setup(20, 2, 32'h0016_F871);
    pulse_start();
    repeat (40) @(negedge clk);
    chk("R2 busy mid scan", 32'(busy), 1);
    pulse_start();
    chk("R2 still busy", 32'(busy), 1);
    wait_done(ok);
    if (ok) check_result(20, 2, 32'h0016_F871);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule